// File: doc/BRIEF.md
# Searchable Pipeline Instruction Queue

This block is the queue that links a decode stage to an execute stage in a short processor pipeline. Each entry is a decoded instruction template: a kind tag, a destination register number and two operand words. The decode side pushes templates. The execute side reads the oldest one and pops it once that instruction has been carried out. A flush input empties the queue when a taken branch makes the prefetched work useless.

Next to the queue sits a combinational lookup port. Decode presents a register number there. The port answers, in the same cycle, whether any template still waiting in the queue will write that register. Decode uses the answer to hold back an instruction whose source operand is not yet final.

Operations within one cycle follow a fixed order. The head read and the pop come first. The lookup and the push come after them, and a flush overrides everything. Two things follow from this order. A full queue still accepts a push in any cycle that also pops. An entry that is being popped no longer counts as pending for the lookup.

Top module: `sfifo_pipe`

## Requirements
- R1: After reset the queue is empty: `head_valid` is 0, `enq_ready` is 1 and `find_hit` is 0 for every register number.
- R2: Templates leave in the order they were accepted. `head_data` always shows the oldest held template while `head_valid` is 1.
- R3: With DEPTH entries held and no pop in the cycle, `enq_ready` is 0. A push attempt is then ignored and the held contents stay unchanged.
- R4: A pop request while the queue is empty is ignored and leaves the queue empty.
- R5: When the queue is full and a pop is accepted in the same cycle, `enq_ready` is 1. A push in that cycle is accepted, so the occupancy stays at DEPTH.
- R6: Entry layout is as follows: bits [70:69] are the kind tag (0 add, 1 branch-if-zero, 2 load, 3 store), bits [68:64] are the destination register, bits [63:32] are the first operand and bits [31:0] are the second operand. An entry matches a looked-up register only if its tag is add or load and its destination equals `find_reg`. Branch and store entries never match.
- R7: `find_hit` is the OR of the matches over all held entries. It follows `find_reg` in the same cycle, with no register in the path, and it is 0 when the queue is empty.
- R8: An entry popped in the current cycle does not contribute to that cycle's `find_hit`.
- R9: `clr` empties the queue at the next edge. A push in the same cycle is discarded, and so is a pop in that cycle.
- R10: A template pushed in the current cycle does not contribute to that cycle's `find_hit`. It first counts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Flush all entries; highest priority |
| enq_valid | input | 1 | Push request |
| enq_data | input | 71 | Template to push |
| enq_ready | output | 1 | A push is accepted this cycle |
| deq_req | input | 1 | Pop request for the head template |
| head_valid | output | 1 | Queue holds at least one template |
| head_data | output | 71 | Oldest held template |
| find_reg | input | 5 | Register number to look up |
| find_hit | output | 1 | Some pending add/load writes `find_reg` |

## Verification
The hardest case to reach is a full queue in the same cycle as a pop, a push and a lookup. In that case the popped head holds the looked-up register and the pushed template writes it too, so the correct `find_hit` is 0. The stimulus first fills the queue with a matching add at the head and then issues all four requests in one cycle. A directed sequence covers the full, empty and flush edges. A pseudo-random run then mixes pushes, pops, rare flushes and small register numbers so that lookups match often.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int TAG_W = 2;

  typedef enum logic [TAG_W-1:0] {
    TPL_ADD   = 2'd0,
    TPL_BZ    = 2'd1,
    TPL_LOAD  = 2'd2,
    TPL_STORE = 2'd3
  } tpl_kind_e;

  // Kinds that write a destination register.
  function automatic logic kind_writes_reg(input logic [TAG_W-1:0] tag);
    return (tag == TPL_ADD) || (tag == TPL_LOAD);
  endfunction

  // Distance of a slot from the head, modulo depth.
  function automatic int slot_age(input int slot, input int head, input int depth);
    return (slot >= head) ? (slot - head) : (slot + depth - head);
  endfunction
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enq_req,
  input  logic             deq_req,
  output logic             enq_fire,
  output logic             deq_fire,
  output logic             enq_ready,
  output logic             empty,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr,
  output logic [CNT_W-1:0] count,
  output logic [DEPTH-1:0] live_mask
);
  import sfifo_pkg::*;

  logic full;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign deq_fire  = deq_req && !empty;
  assign enq_ready = !full || deq_fire;
  assign enq_fire  = enq_req && enq_ready && !clr;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live_mask[i] = slot_age(i, int'(head_ptr), DEPTH) < int'(count);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      count    <= '0;
    end else begin
      if (enq_fire) tail_ptr <= ptr_inc(tail_ptr);
      if (deq_fire) head_ptr <= ptr_inc(head_ptr);
      case ({enq_fire, deq_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH  = 2,
  parameter int ITEM_W = 71,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PTR_W-1:0]        wr_ptr,
  input  logic [ITEM_W-1:0]       wr_data,
  input  logic [PTR_W-1:0]        rd_ptr,
  output logic [ITEM_W-1:0]       rd_data,
  output logic [DEPTH*ITEM_W-1:0] slots_flat
);
  logic [ITEM_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (wr_en && (wr_ptr == PTR_W'(g)))
        mem[g] <= wr_data;
    end
    assign slots_flat[g*ITEM_W +: ITEM_W] = mem[g];
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/sfifo_search.sv
module sfifo_search #(
  parameter int DEPTH  = 2,
  parameter int REG_W  = 5,
  parameter int ITEM_W = 71
) (
  input  logic [DEPTH*ITEM_W-1:0] slots_flat,
  input  logic [DEPTH-1:0]        search_mask,
  input  logic [REG_W-1:0]        find_reg,
  output logic [DEPTH-1:0]        slot_match,
  output logic                    hit
);
  import sfifo_pkg::*;

  localparam int TAG_LSB = ITEM_W - TAG_W;
  localparam int DST_LSB = TAG_LSB - REG_W;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [ITEM_W-1:0] ent;
    assign ent = slots_flat[g*ITEM_W +: ITEM_W];
    assign slot_match[g] = search_mask[g]
                         && kind_writes_reg(ent[TAG_LSB +: TAG_W])
                         && (ent[DST_LSB +: REG_W] == find_reg);
  end

  assign hit = |slot_match;
endmodule

// File: rtl/sfifo_pipe.sv
module sfifo_pipe #(
  parameter int DEPTH  = 2,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int ITEM_W = sfifo_pkg::TAG_W + REG_W + 2 * DATA_W,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              enq_valid,
  input  logic [ITEM_W-1:0] enq_data,
  output logic              enq_ready,
  input  logic              deq_req,
  output logic              head_valid,
  output logic [ITEM_W-1:0] head_data,
  input  logic [REG_W-1:0]  find_reg,
  output logic              find_hit
);
  logic                    enq_fire, deq_fire, empty;
  logic [PTR_W-1:0]        head_ptr, tail_ptr;
  logic [CNT_W-1:0]        count;
  logic [DEPTH-1:0]        live_mask, head_onehot, search_mask, slot_match;
  logic [DEPTH*ITEM_W-1:0] slots_flat;

  sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .enq_req(enq_valid), .deq_req(deq_req),
    .enq_fire(enq_fire), .deq_fire(deq_fire), .enq_ready(enq_ready),
    .empty(empty), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
    .count(count), .live_mask(live_mask)
  );

  sfifo_store #(.DEPTH(DEPTH), .ITEM_W(ITEM_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(enq_fire), .wr_ptr(tail_ptr),
    .wr_data(enq_data), .rd_ptr(head_ptr), .rd_data(head_data),
    .slots_flat(slots_flat)
  );

  // Lookup is ordered after the pop: the leaving head is masked out.
  always_comb begin
    head_onehot = '0;
    head_onehot[head_ptr] = 1'b1;
  end
  assign search_mask = live_mask & ~(deq_fire ? head_onehot : '0);

  sfifo_search #(.DEPTH(DEPTH), .REG_W(REG_W), .ITEM_W(ITEM_W)) u_search (
    .slots_flat(slots_flat), .search_mask(search_mask),
    .find_reg(find_reg), .slot_match(slot_match), .hit(find_hit)
  );

  assign head_valid = !empty;
endmodule

// File: rtl/sfifo_pipe_chk.sv
module sfifo_pipe_chk #(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             enq_valid,
  input logic             enq_ready,
  input logic             head_valid,
  input logic             find_hit,
  input logic             enq_fire,
  input logic             deq_fire,
  input logic [CNT_W-1:0] count
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && !deq_fire && !clr) |-> !enq_ready ##1 count == CNT_W'(DEPTH));

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !enq_fire && !clr) |=> (count == '0 && !head_valid));

  assert_swap_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && deq_fire && enq_valid && !clr) |=> count == CNT_W'(DEPTH));

  assert_pop_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    deq_fire |-> enq_ready);

  assert_empty_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |-> !find_hit);

  assert_last_leaving_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_fire && count == CNT_W'(1)) |-> !find_hit);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !head_valid));
endmodule

bind sfifo_pipe sfifo_pipe_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .enq_valid(enq_valid),
  .enq_ready(enq_ready), .head_valid(head_valid), .find_hit(find_hit),
  .enq_fire(enq_fire), .deq_fire(deq_fire), .count(count)
);

// File: tb/sim_sfifo_pipe.sv
module sim_sfifo_pipe;
  localparam int DEPTH = 2;
  localparam int IW    = 71;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          enq_valid = 1'b0;
  logic [IW-1:0] enq_data = '0;
  logic          enq_ready;
  logic          deq_req = 1'b0;
  logic          head_valid;
  logic [IW-1:0] head_data;
  logic [4:0]    find_reg = '0;
  logic          find_hit;

  int checks = 0;
  int errors = 0;
  logic [IW-1:0] sb[$];

  always #5 clk = ~clk;

  sfifo_pipe u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .enq_valid(enq_valid),
    .enq_data(enq_data), .enq_ready(enq_ready), .deq_req(deq_req),
    .head_valid(head_valid), .head_data(head_data),
    .find_reg(find_reg), .find_hit(find_hit)
  );

  function automatic logic [IW-1:0] tpl(input logic [1:0] kind, input logic [4:0] dst,
                                        input logic [31:0] a, input logic [31:0] b);
    return {kind, dst, a, b};
  endfunction

  // Restated lookup rule: adds (0) and loads (2) write their destination.
  function automatic logic pending_write(input logic [IW-1:0] t, input logic [4:0] r);
    return (t[70:69] == 2'd0 || t[70:69] == 2'd2) && t[68:64] == r;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [IW-1:0] act, input logic [IW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: compares ports against the scoreboard, then retires the cycle.
  task automatic monitor(input string req);
    logic pop_ok, push_ok, exp_hit;
    pop_ok  = deq_req && sb.size() > 0;
    push_ok = enq_valid && (sb.size() < DEPTH || pop_ok) && !clr;
    exp_hit = 1'b0;
    for (int k = 0; k < sb.size(); k++)
      if (!(pop_ok && k == 0) && pending_write(sb[k], find_reg)) exp_hit = 1'b1;
    check(head_valid == (sb.size() > 0), req, "head_valid", IW'(head_valid), IW'(sb.size() > 0));
    check(enq_ready == (sb.size() < DEPTH || pop_ok), req, "enq_ready",
          IW'(enq_ready), IW'(sb.size() < DEPTH || pop_ok));
    check(find_hit == exp_hit, req, "find_hit", IW'(find_hit), IW'(exp_hit));
    if (sb.size() > 0)
      check(head_data == sb[0], req, "head_data", head_data, sb[0]);
    if (clr) sb.delete();
    else begin
      if (pop_ok) void'(sb.pop_front());
      if (push_ok) sb.push_back(enq_data);
    end
  endtask

  // Driver: applies one cycle of requests away from the rising edge.
  task automatic drive(input logic ev, input logic [IW-1:0] d, input logic dq,
                       input logic cl, input logic [4:0] fr, input string req);
    @(negedge clk);
    enq_valid = ev; enq_data = d; deq_req = dq; clr = cl; find_reg = fr;
    #2;
    monitor(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: empty after reset, no hit on any register
    drive(0, '0, 0, 0, 5'd0, "R1");
    drive(0, '0, 0, 0, 5'd31, "R1");
    // R10: pushed add on r3 not visible in its own cycle
    drive(1, tpl(2'd0, 5'd3, 32'h11, 32'h22), 0, 0, 5'd3, "R10");
    // R6: add on r3 matches next cycle
    drive(0, '0, 0, 0, 5'd3, "R6");
    // R6: store with dst 5 never matches
    drive(1, tpl(2'd3, 5'd5, 32'h33, 32'h44), 0, 0, 5'd5, "R6");
    drive(0, '0, 0, 0, 5'd5, "R6");
    // R3: full, push without pop ignored
    drive(1, tpl(2'd2, 5'd7, 32'h55, 32'h66), 0, 0, 5'd3, "R3");
    // R5 + R8: full, pop head (add r3) and push load r3; lookup r3 must miss
    drive(1, tpl(2'd2, 5'd3, 32'h77, 32'h88), 1, 0, 5'd3, "R8");
    drive(0, '0, 0, 0, 5'd3, "R5");
    // R7: OR over entries
    drive(0, '0, 0, 0, 5'd3, "R7");
    // R2: drain in order
    drive(0, '0, 1, 0, 5'd0, "R2");
    drive(0, '0, 1, 0, 5'd0, "R2");
    // R4: pop on empty ignored
    drive(0, '0, 1, 0, 5'd0, "R4");
    drive(0, '0, 0, 0, 5'd0, "R4");
    // R6: branch never matches
    drive(1, tpl(2'd1, 5'd9, 32'h0, 32'h9), 0, 0, 5'd9, "R6");
    drive(0, '0, 0, 0, 5'd9, "R6");
    // R9: flush with push and pop in the same cycle
    drive(1, tpl(2'd0, 5'd9, 32'h1, 32'h2), 1, 1, 5'd9, "R9");
    drive(0, '0, 0, 0, 5'd9, "R9");
    drive(1, tpl(2'd0, 5'd4, 32'h3, 32'h4), 0, 0, 5'd4, "R9");
    drive(1, tpl(2'd2, 5'd6, 32'h5, 32'h6), 0, 1, 5'd4, "R9");
    drive(0, '0, 0, 0, 5'd4, "R9");
    // Mixed traffic for R2/R7
    lf = 32'hACE1_2357;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      drive(lf[0], tpl(lf[9:8], {2'b00, lf[12:10]}, lf, ~lf), lf[1] | lf[2],
            lf[7:3] == 5'd0, {2'b00, lf[15:13]}, "R2");
    end
    drive(0, '0, 0, 0, 5'd0, "R7");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule